// File: doc/BRIEF.md
# Startup-Guarded Byte-Wide USB FIFO Transmit Bridge

This block connects a user-side stream of 32-bit words to an 8-bit synchronous parallel FIFO port on a USB bridge chip. The bridge signals free transmit space and pending receive data with active-low flags. The block drives active-low output-enable, read and write strobes, and puts data on a byte bus whose drive is controlled by an enable.

After a cold start the bridge's transmit-space flag can change state for a while. If a word started during that time, its bytes could reach the host out of alignment. To prevent this, the block holds every strobe inactive until the transmit-space flag has stayed asserted for a long, unbroken run of cycles. Any break in the run restarts the count.

Once that guard has been met, the block takes one user word at a time and sends it as an unbroken group of bytes, least significant first. It pauses on the current byte whenever the bridge has no space. When no word is offered and the bridge reports receive data, the block runs a simple read burst and presents each captured byte for one cycle.

Top module: `usbFifoBridge`

## Requirements
- R1: While `rstN` is low, `outEnN`, `rdStrobeN` and `wrStrobeN` are high, and `txReady` and `busDrive` are low.
- R2: After reset, `txReady` first rises on the clock edge after `txSpaceN` has been sampled low on QUAL_LIMIT consecutive edges. An edge that samples `txSpaceN` high restarts the run from zero.
- R3: Until the guard of R2 is met, all three strobes stay high, whatever `rxAvailN` and `txValid` do.
- R4: `txReady` is high only in the idle state after the guard. It is low on every cycle in which a word is partly sent.
- R5: An accepted word `w` leaves as four bytes in order. Byte k is `w[8k+7:8k]`, for k = 0 to 3.
- R6: `wrStrobeN` is low only in a cycle where `txSpaceN` is low, and then for exactly one cycle per byte. Each word produces exactly four write cycles.
- R7: While `txSpaceN` is high in the middle of a word, the byte on `busOut` and its position are held. Sending resumes with that same byte.
- R8: From the first byte of a word to its last, `outEnN` and `rdStrobeN` stay high, even while `rxAvailN` is low.
- R9: A read burst lowers `outEnN` for one cycle with `rdStrobeN` high. After that, `rdStrobeN` is low on every cycle where `rxAvailN` is low, while `outEnN` stays low. A byte sampled from `busIn` on such an edge appears on `rxByte`, with `rxByteValid` high, in the following cycle.
- R10: In the idle state, an offered word takes priority over pending receive data.
- R11: `busDrive` is high only while a word is being sent. It is never high while `outEnN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txSpaceN | input | 1 | Bridge can accept a byte (active low) |
| rxAvailN | input | 1 | Bridge holds receive data (active low) |
| busIn | input | 8 | Byte bus as seen from the bridge |
| busOut | output | 8 | Byte driven toward the bridge |
| busDrive | output | 1 | Enable for driving `busOut` onto the bus |
| outEnN | output | 1 | Bridge output enable (active low) |
| rdStrobeN | output | 1 | Read strobe (active low) |
| wrStrobeN | output | 1 | Write strobe (active low) |
| txWord | input | 32 | User word to send |
| txValid | input | 1 | `txWord` is offered |
| txReady | output | 1 | Word accepted on this edge if valid |
| rxByte | output | 8 | Last byte read from the bridge |
| rxByteValid | output | 1 | `rxByte` is new this cycle |

## Verification
The bench builds the block with QUAL_LIMIT set to 20 instead of six million. This makes the exact edge where `txReady` first rises observable, as well as the effect of a one-cycle break in the ready run partway through the guard. With the wait that short, the bench sweeps all sixteen patterns of stalls before the four byte positions, two times each with distinct words. It also runs a word offered together with pending receive data, followed by a four-byte read burst.

// File: rtl/usbFifoBridgePkg.sv
`timescale 1ns/1ps
package usbFifoBridgePkg;
  typedef enum logic [2:0] {
    ST_GUARD,
    ST_IDLE,
    ST_SEND,
    ST_RDOE,
    ST_RDACT
  } ctlState_t;

  typedef struct packed {
    logic loadWord;
    logic advance;
    logic captureRx;
  } dpStrobe_t;
endpackage

// File: rtl/bridgeDatapath.sv
`timescale 1ns/1ps
module bridgeDatapath
  import usbFifoBridgePkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] txWord,
  input  logic [BYTE_W-1:0] busIn,
  output logic [BYTE_W-1:0] busOut,
  output logic              lastByte,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxByteValid
);
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [WORD_W-1:0] wordReg;
  logic [IDX_W-1:0]  byteIdx;

  assign busOut   = wordReg[byteIdx*BYTE_W +: BYTE_W];
  assign lastByte = (byteIdx == IDX_W'(NBYTES-1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg <= '0;
      byteIdx <= '0;
    end else if (strobe.loadWord) begin
      wordReg <= txWord;
      byteIdx <= '0;
    end else if (strobe.advance) begin
      byteIdx <= lastByte ? '0 : byteIdx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte      <= '0;
      rxByteValid <= 1'b0;
    end else begin
      rxByteValid <= strobe.captureRx;
      if (strobe.captureRx) rxByte <= busIn;
    end
  end
endmodule

// File: rtl/bridgeControl.sv
`timescale 1ns/1ps
module bridgeControl
  import usbFifoBridgePkg::*;
#(
  parameter int QUAL_LIMIT = 6000000,
  parameter int CNT_W      = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txSpaceN,
  input  logic      rxAvailN,
  input  logic      txValid,
  input  logic      lastByte,
  output dpStrobe_t strobe,
  output logic      txReady,
  output logic      busDrive,
  output logic      outEnN,
  output logic      rdStrobeN,
  output logic      wrStrobeN
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(QUAL_LIMIT);

  ctlState_t        state, stateNext;
  logic [CNT_W-1:0] qualCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualCnt <= '0;
    end else if (state == ST_GUARD && qualCnt < LIMIT) begin
      qualCnt <= txSpaceN ? '0 : qualCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_GUARD;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    txReady   = 1'b0;
    busDrive  = 1'b0;
    outEnN    = 1'b1;
    rdStrobeN = 1'b1;
    wrStrobeN = 1'b1;
    unique case (state)
      ST_GUARD: begin
        if (qualCnt >= LIMIT) stateNext = ST_IDLE;
      end
      ST_IDLE: begin
        txReady = 1'b1;
        if (txValid) begin
          strobe.loadWord = 1'b1;
          stateNext       = ST_SEND;
        end else if (!rxAvailN) begin
          stateNext = ST_RDOE;
        end
      end
      ST_SEND: begin
        busDrive       = 1'b1;
        wrStrobeN      = txSpaceN;
        strobe.advance = !txSpaceN;
        if (!txSpaceN && lastByte) stateNext = ST_IDLE;
      end
      ST_RDOE: begin
        outEnN    = 1'b0;
        stateNext = ST_RDACT;
      end
      ST_RDACT: begin
        outEnN           = 1'b0;
        rdStrobeN        = rxAvailN;
        strobe.captureRx = !rxAvailN;
        if (rxAvailN) stateNext = ST_IDLE;
      end
      default: stateNext = ST_GUARD;
    endcase
  end
endmodule

// File: rtl/usbFifoBridge.sv
`timescale 1ns/1ps
module usbFifoBridge
  import usbFifoBridgePkg::*;
#(
  parameter int QUAL_LIMIT = 6000000,
  parameter int WORD_W     = 32,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txSpaceN,
  input  logic              rxAvailN,
  input  logic [BYTE_W-1:0] busIn,
  output logic [BYTE_W-1:0] busOut,
  output logic              busDrive,
  output logic              outEnN,
  output logic              rdStrobeN,
  output logic              wrStrobeN,
  input  logic [WORD_W-1:0] txWord,
  input  logic              txValid,
  output logic              txReady,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxByteValid
);
  dpStrobe_t strobe;
  logic      lastByte;

  bridgeControl #(.QUAL_LIMIT(QUAL_LIMIT)) uCtl (
    .clk(clk), .rstN(rstN), .txSpaceN(txSpaceN), .rxAvailN(rxAvailN),
    .txValid(txValid), .lastByte(lastByte), .strobe(strobe),
    .txReady(txReady), .busDrive(busDrive), .outEnN(outEnN),
    .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN)
  );

  bridgeDatapath #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txWord(txWord),
    .busIn(busIn), .busOut(busOut), .lastByte(lastByte),
    .rxByte(rxByte), .rxByteValid(rxByteValid)
  );
endmodule

// File: rtl/usbFifoBridgeChk.sv
`timescale 1ns/1ps
module usbFifoBridgeChk #(
  parameter int QUAL_LIMIT = 6000000,
  parameter int BYTE_W     = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              txSpaceN,
  input logic [BYTE_W-1:0] busOut,
  input logic              busDrive,
  input logic              outEnN,
  input logic              rdStrobeN,
  input logic              wrStrobeN,
  input logic              txReady
);
  logic [31:0] seenCnt;
  logic        qualSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenCnt  <= '0;
      qualSeen <= 1'b0;
    end else if (!qualSeen) begin
      if (seenCnt >= 32'(QUAL_LIMIT)) qualSeen <= 1'b1;
      else seenCnt <= txSpaceN ? '0 : seenCnt + 32'd1;
    end
  end

  // R2
  ready_after_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> qualSeen);
  // R3
  quiet_in_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    !qualSeen |-> (outEnN && rdStrobeN && wrStrobeN));
  // R4
  no_ready_while_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> !txReady);
  // R6
  wr_needs_space_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobeN |-> (!txSpaceN && busDrive));
  // R7
  stall_holds_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busDrive && txSpaceN) |=> (busDrive && $stable(busOut)));
  // R9
  rd_inside_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobeN |-> !outEnN);
  // R9
  oe_leads_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdStrobeN) |-> $past(!outEnN));
  // R11
  no_drive_with_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outEnN |-> !busDrive);
endmodule

bind usbFifoBridge usbFifoBridgeChk #(.QUAL_LIMIT(QUAL_LIMIT), .BYTE_W(BYTE_W)) uChk (
  .clk(clk), .rstN(rstN), .txSpaceN(txSpaceN), .busOut(busOut),
  .busDrive(busDrive), .outEnN(outEnN), .rdStrobeN(rdStrobeN),
  .wrStrobeN(wrStrobeN), .txReady(txReady)
);

// File: tb/sim_usbFifoBridge.sv
`timescale 1ns/1ps
module sim_usbFifoBridge;
  localparam int LIM = 20;

  logic        clk = 1'b0;
  logic        rstN, txSpaceN, rxAvailN, txValid;
  logic [7:0]  busIn;
  logic [31:0] txWord;
  logic [7:0]  busOut, rxByte;
  logic        busDrive, outEnN, rdStrobeN, wrStrobeN, txReady, rxByteValid;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  usbFifoBridge #(.QUAL_LIMIT(LIM)) u0 (
    .clk(clk), .rstN(rstN), .txSpaceN(txSpaceN), .rxAvailN(rxAvailN),
    .busIn(busIn), .busOut(busOut), .busDrive(busDrive), .outEnN(outEnN),
    .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN), .txWord(txWord),
    .txValid(txValid), .txReady(txReady), .rxByte(rxByte),
    .rxByteValid(rxByteValid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [31:0] w, input logic [3:0] stallMask,
                          input logic rxLow);
    txWord   = w;
    txValid  = 1'b1;
    rxAvailN = !rxLow;
    #1 chk(txReady == 1'b1, "R4 ready in idle", 32'(txReady), 32'd1);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] expB;
      expB = w[8*k +: 8];
      @(negedge clk);
      txValid = 1'b0;
      if (stallMask[k]) begin
        txSpaceN = 1'b1;
        #1;
        chk(wrStrobeN == 1'b1, "R6 no write while full", 32'(wrStrobeN), 32'd1);
        chk(busOut == expB, "R7 byte held in stall", 32'(busOut), 32'(expB));
        chk(txReady == 1'b0, "R4 not ready mid-word", 32'(txReady), 32'd0);
        @(negedge clk);
        txSpaceN = 1'b0;
      end
      #1;
      chk(wrStrobeN == 1'b0, "R6 write pulse", 32'(wrStrobeN), 32'd0);
      chk(busOut == expB, "R5 byte order", 32'(busOut), 32'(expB));
      chk(outEnN && rdStrobeN, "R8 no read inside word",
          {30'd0, outEnN, rdStrobeN}, 32'd3);
      chk(busDrive == 1'b1, "R11 drive while sending", 32'(busDrive), 32'd1);
    end
    @(negedge clk);
    #1;
    chk(wrStrobeN == 1'b1, "R6 exactly four writes", 32'(wrStrobeN), 32'd1);
    chk(txReady == 1'b1, "R4 ready after word", 32'(txReady), 32'd1);
  endtask

  initial begin
    rstN = 1'b0; txSpaceN = 1'b1; rxAvailN = 1'b1; txValid = 1'b0;
    txWord = '0; busIn = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(outEnN && rdStrobeN && wrStrobeN, "R1 strobes idle in reset",
        {29'd0, outEnN, rdStrobeN, wrStrobeN}, 32'd7);
    chk(!txReady && !busDrive, "R1 no ready/drive in reset",
        {30'd0, txReady, busDrive}, 32'd0);

    @(negedge clk);
    rstN = 1'b1; txSpaceN = 1'b0; rxAvailN = 1'b0; txValid = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      #1;
      chk(outEnN && rdStrobeN && wrStrobeN && !txReady, "R3 quiet in guard",
          {28'd0, outEnN, rdStrobeN, wrStrobeN, txReady}, 32'he);
    end
    @(negedge clk);
    txSpaceN = 1'b1;
    @(negedge clk);
    txSpaceN = 1'b0; rxAvailN = 1'b1; txValid = 1'b0;
    for (int k = 1; k <= LIM; k++) begin
      @(negedge clk);
      #1 chk(txReady == 1'b0, "R2 guard still counting", 32'(txReady), 32'd0);
    end
    @(negedge clk);
    #1 chk(txReady == 1'b1, "R2 guard met on next edge", 32'(txReady), 32'd1);

    for (int i = 0; i < 32; i++) begin
      sendWord(32'h9E3779B9 * 32'(i + 1), 4'(i % 16), 1'b0);
    end

    sendWord(32'hC0FFEE11, 4'b0000, 1'b1);
    sendWord(32'h8844AA22, 4'b0010, 1'b1);
    txValid = 1'b0;
    @(negedge clk);
    #1;
    chk(outEnN == 1'b0 && rdStrobeN == 1'b1, "R9 oe leads rd",
        {30'd0, outEnN, rdStrobeN}, 32'd1);
    chk(busDrive == 1'b0, "R11 no drive in read", 32'(busDrive), 32'd0);
    busIn = 8'h3C;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      #1;
      chk(outEnN == 1'b0 && rdStrobeN == 1'b0, "R9 rd with oe",
          {30'd0, outEnN, rdStrobeN}, 32'd0);
      if (j == 0) chk(rxByteValid == 1'b0, "R9 no early byte", 32'(rxByteValid), 32'd0);
      else chk(rxByteValid && rxByte == 8'(8'h3C + 37 * (j - 1)), "R9 captured byte",
               {23'd0, rxByteValid, rxByte}, {23'd0, 1'b1, 8'(8'h3C + 37 * (j - 1))});
      busIn = 8'(8'h3C + 37 * j);
    end
    @(negedge clk);
    #1;
    chk(rxByteValid && rxByte == 8'(8'h3C + 37 * 3), "R9 last captured byte",
        {23'd0, rxByteValid, rxByte}, {23'd0, 1'b1, 8'(8'h3C + 37 * 3)});
    rxAvailN = 1'b1;
    @(negedge clk);
    #1;
    chk(outEnN && rdStrobeN && !rxByteValid, "R9 burst ends",
        {29'd0, outEnN, rdStrobeN, rxByteValid}, 32'd6);
    chk(txReady == 1'b1, "R10 back to idle", 32'(txReady), 32'd1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule